// File: doc/BRIEF.md
# SDRAM Bank Timing and Command Checker

This block watches the command pins of an SDRAM interface and keeps a model of four banks. It decodes every command on the rising clock edge, judges whether the command is legal in the current bank state and timing window, and reports the verdict one cycle later as an accept pulse or a reject pulse with a reason code. All minimum spacings are parameters counted in whole clock cycles. The defaults are for a 7.5 ns clock: row cycle 9, active-to-precharge 6, activate-to-column 3, precharge 3, bank-to-bank activate 2, write recovery 2 and mode-set recovery 2.

A rejected command does not change the model, so a single bad command does not affect the verdicts that follow it. The block also tracks one burst at a time. It uses the burst length from the last accepted mode-register write to time auto-precharge recovery, to protect auto-precharge bursts from interruption, and to decide when a burst stop is legal. The current open/closed state of each bank is always visible at the output.

Top module: `sdram_cmd_checker`

## Requirements
- R1: Command encoding on {cs_n,ras_n,cas_n,we_n}. Deselect is 1xxx and no-op is 0111. The other commands are activate 0011, read 0101, write 0100, precharge 0010, refresh 0001, mode set 0000 and burst stop 0110. One cycle after each command other than no-op or deselect, exactly one of `cmd_ok`/`cmd_bad` pulses, and `bad_code` is 0 on accept and nonzero on reject. No-op and deselect produce neither pulse. After reset all banks are closed and no pulse is present.
- R2: A rejected command leaves `bank_open` and all timing state as they were.
- R3: An activate to an open bank is rejected with code 3. An accepted activate sets that bank's bit in `bank_open`.
- R4: A read or write to a closed bank is rejected with code 3. A read or write issued fewer than T_RCD cycles after that bank's activate is rejected with code 9.
- R5: An activate fewer than T_RC cycles after the previous activate of the same bank is rejected with code 5. An activate fewer than T_RRD cycles after any accepted activate is rejected with code 6.
- R6: Precharge with addr[10]=1 closes every bank, and with addr[10]=0 closes only bank `ba`. Precharge of a closed bank is accepted and changes nothing. A precharge that would close a bank opened fewer than T_RAS cycles earlier is rejected with code 7. An activate fewer than T_RP cycles after its bank was closed by precharge is rejected with code 8.
- R7: A read or write with addr[10]=1 closes its bank at once. The bank may be activated again no sooner than BL-1+T_RP cycles after a read, or BL-1+T_WR+T_RP cycles after a write. An earlier activate is rejected with code 8.
- R8: During the beats of a burst that carries auto-precharge, any read, write or precharge is rejected with code 2.
- R9: A read or write with addr[10]=1 while full-page burst length is selected is rejected with code 10.
- R10: A burst stop is accepted only while a full-page burst is running, and it ends that burst. Otherwise it is rejected with code 11.
- R11: Refresh and mode set need every bank closed and past its precharge recovery. Otherwise they are rejected with code 4. After an accepted refresh, an activate to any bank within T_RC cycles is rejected with code 5.
- R12: A mode set loads the burst length from addr[2:0]: 000=1, 001=2, 010=4, 011=8, 111=full page. The other values are rejected with code 12. After reset the burst length is 4. Any command within T_RSC cycles after an accepted mode set is rejected with code 1.
- R13: When several rules fail, the reported code follows the order 1, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, with the lowest number winning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Address; bit AP_BIT selects all-bank / auto-precharge, bits 2:0 carry burst length on mode set |
| cmd_ok | output | 1 | One-cycle pulse: previous command accepted |
| cmd_bad | output | 1 | One-cycle pulse: previous command rejected |
| bad_code | output | 4 | Reason for rejection, 0 when accepted |
| bank_open | output | 2**BA_W | One bit per bank, 1 when the row is open |

## Verification
The bound assertions check the following on every cycle: the two verdict pulses are exclusive; the code agrees with the verdict; no-op and deselect stay silent while real commands always get a verdict; a rejected command leaves the bank state untouched; an accepted activate opens its bank and an activate to an open bank is refused; an accepted column command found its bank open; and a command right after a mode set is refused for recovery. The exact cycle counts are shown only by the bench's scenarios. These include activate-to-column delay, row cycle and bank-to-bank spacing, precharge windows, the longer recovery after auto-precharge writes as opposed to reads, recovery that follows a newly programmed burst length, full-page burst-stop handling, and the ordering of reason codes.

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int T_RC   = 9,
  parameter int T_RAS  = 6,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 3,
  parameter int T_RRD  = 2,
  parameter int T_WR   = 2,
  parameter int T_RSC  = 2,
  parameter logic [2:0] BL_RESET = 3'b010
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 cmd_ok,
  output logic                 cmd_bad,
  output logic [3:0]           bad_code,
  output logic [(1<<BA_W)-1:0] bank_open
);
  localparam int NB = 1 << BA_W;
  localparam int CW = $clog2(T_RC + T_RAS + T_RCD + T_RP + T_RRD + T_WR + T_RSC + 16);

  function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
    return (v == '0) ? v : v - CW'(1);
  endfunction

  // command decode
  wire sel    = !cs_n;
  wire is_act = sel & !ras_n &  cas_n &  we_n;
  wire is_rd  = sel &  ras_n & !cas_n &  we_n;
  wire is_wr  = sel &  ras_n & !cas_n & !we_n;
  wire is_pre = sel & !ras_n &  cas_n & !we_n;
  wire is_ref = sel & !ras_n & !cas_n &  we_n;
  wire is_mrs = sel & !ras_n & !cas_n & !we_n;
  wire is_bst = sel &  ras_n &  cas_n & !we_n;
  wire is_col = is_rd | is_wr;
  wire is_cmd = is_act | is_col | is_pre | is_ref | is_mrs | is_bst;
  wire ap     = addr[AP_BIT];

  logic unused_addr;
  assign unused_addr = ^addr;

  // mode and burst state
  logic [2:0]      bl_code;
  logic [CW-1:0]   bl_left;
  logic            burst_full, burst_ap;
  logic [BA_W-1:0] burst_bank;
  logic [CW-1:0]   rrd_c, rsc_c, ref_c;

  wire            full_page = (bl_code == 3'b111);
  wire [CW-1:0]   bl_beats  = CW'(1) << bl_code[1:0];
  wire            bl_legal  = !addr[2] || (addr[2:0] == 3'b111);
  wire            burst_on  = (bl_left != '0) || burst_full;
  wire            ap_busy   = burst_on && burst_ap;
  wire [CW-1:0]   ap_rec    = bl_beats + CW'(T_RP) - CW'(2) + (is_wr ? CW'(T_WR) : CW'(0));

  // per-bank readiness flags
  logic [NB-1:0] open_q, rc_z, ras_z, rcd_z, rp_z;
  logic          accept;
  logic [3:0]    code;

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_bank
      logic [CW-1:0] rc_c, ras_c, rcd_c, rp_c;
      logic          op;
      wire hit      = (ba == BA_W'(gi));
      wire do_act   = accept && is_act && hit;
      wire do_pre   = accept && is_pre && (ap || hit) && op;
      wire do_apcol = accept && is_col && ap && hit;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          op <= 1'b0; rc_c <= '0; ras_c <= '0; rcd_c <= '0; rp_c <= '0;
        end else begin
          if (do_act) begin
            op    <= 1'b1;
            rc_c  <= CW'(T_RC - 1);
            ras_c <= CW'(T_RAS - 1);
            rcd_c <= CW'(T_RCD - 1);
          end else begin
            if (do_pre || do_apcol) op <= 1'b0;
            rc_c  <= dn(rc_c);
            ras_c <= dn(ras_c);
            rcd_c <= dn(rcd_c);
          end
          if (do_pre)        rp_c <= CW'(T_RP - 1);
          else if (do_apcol) rp_c <= ap_rec;
          else               rp_c <= dn(rp_c);
        end
      end

      assign open_q[gi] = op;
      assign rc_z[gi]   = (rc_c == '0);
      assign ras_z[gi]  = (ras_c == '0);
      assign rcd_z[gi]  = (rcd_c == '0);
      assign rp_z[gi]   = (rp_c == '0);
    end
  endgenerate

  wire all_idle = (open_q == '0) && (&rp_z);
  wire ras_any  = |(open_q & ~ras_z);

  // verdict, lowest code wins
  always_comb begin
    code = 4'd0;
    if (rsc_c != '0)                                         code = 4'd1;
    else if ((is_col || is_pre) && ap_busy)                  code = 4'd2;
    else if ((is_act && open_q[ba]) || (is_col && !open_q[ba])) code = 4'd3;
    else if ((is_ref || is_mrs) && !all_idle)                code = 4'd4;
    else if (is_act && (!rc_z[ba] || ref_c != '0))           code = 4'd5;
    else if (is_act && rrd_c != '0)                          code = 4'd6;
    else if (is_pre && (ap ? ras_any : (open_q[ba] && !ras_z[ba]))) code = 4'd7;
    else if (is_act && !rp_z[ba])                            code = 4'd8;
    else if (is_col && !rcd_z[ba])                           code = 4'd9;
    else if (is_col && ap && full_page)                      code = 4'd10;
    else if (is_bst && !(burst_on && burst_full))            code = 4'd11;
    else if (is_mrs && !bl_legal)                            code = 4'd12;
    if (!is_cmd) code = 4'd0;
  end

  assign accept = is_cmd && (code == 4'd0);

  wire burst_kill = accept && (is_bst || (is_pre && (ap || ba == burst_bank)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_code    <= BL_RESET;
      bl_left    <= '0;
      burst_full <= 1'b0;
      burst_ap   <= 1'b0;
      burst_bank <= '0;
      rrd_c      <= '0;
      rsc_c      <= '0;
      ref_c      <= '0;
      cmd_ok     <= 1'b0;
      cmd_bad    <= 1'b0;
      bad_code   <= 4'd0;
    end else begin
      rrd_c <= (accept && is_act) ? CW'(T_RRD - 1) : dn(rrd_c);
      rsc_c <= (accept && is_mrs) ? CW'(T_RSC - 1) : dn(rsc_c);
      ref_c <= (accept && is_ref) ? CW'(T_RC - 1)  : dn(ref_c);
      if (accept && is_mrs) bl_code <= addr[2:0];

      if (accept && is_col) begin
        bl_left    <= full_page ? '0 : bl_beats - CW'(1);
        burst_full <= full_page;
        burst_ap   <= ap;
        burst_bank <= ba;
      end else if (burst_kill) begin
        bl_left    <= '0;
        burst_full <= 1'b0;
      end else begin
        bl_left <= dn(bl_left);
      end

      cmd_ok   <= accept;
      cmd_bad  <= is_cmd && (code != 4'd0);
      bad_code <= code;
    end
  end

  assign bank_open = open_q;
endmodule

// File: rtl/sdram_cmd_checker_sva.sv
module sdram_cmd_checker_sva #(
  parameter int BA_W  = 2,
  parameter int T_RSC = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic [BA_W-1:0]      ba,
  input logic                 cmd_ok,
  input logic                 cmd_bad,
  input logic [3:0]           bad_code,
  input logic [(1<<BA_W)-1:0] bank_open
);
  wire real_cmd = !cs_n && !(ras_n && cas_n && we_n);
  wire c_act    = !cs_n && !ras_n && cas_n && we_n;
  wire c_col    = !cs_n && ras_n && !cas_n;
  wire c_mrs    = !cs_n && !ras_n && !cas_n && !we_n;

  logic                 act_d, col_d, mrs_d, sel_open_d;
  logic [BA_W-1:0]      ba_d;
  logic [(1<<BA_W)-1:0] open_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_d <= 1'b0; col_d <= 1'b0; mrs_d <= 1'b0; sel_open_d <= 1'b0;
      ba_d <= '0; open_d <= '0;
    end else begin
      act_d      <= c_act;
      col_d      <= c_col;
      mrs_d      <= c_mrs;
      ba_d       <= ba;
      sel_open_d <= bank_open[ba];
      open_d     <= bank_open;
    end
  end

  assert_one_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ok && cmd_bad));
  assert_code_matches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok |-> bad_code == 4'd0) and (cmd_bad |-> bad_code != 4'd0));
  assert_nop_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !real_cmd |=> (!cmd_ok && !cmd_bad));
  assert_cmd_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    real_cmd |=> (cmd_ok || cmd_bad));
  assert_reject_keeps_banks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bad |-> bank_open == open_d);
  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_d && cmd_ok) |-> bank_open[ba_d]);
  assert_act_open_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_d && sel_open_d) |-> cmd_bad);
  assert_col_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_d && cmd_ok) |-> sel_open_d);

  generate
    if (T_RSC >= 2) begin : g_rsc
      assert_mode_recovery_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_d && cmd_ok && real_cmd) |=> (cmd_bad && bad_code == 4'd1));
    end
  endgenerate
endmodule

bind sdram_cmd_checker sdram_cmd_checker_sva #(.BA_W(BA_W), .T_RSC(T_RSC)) u_sva (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .ba(ba), .cmd_ok(cmd_ok), .cmd_bad(cmd_bad), .bad_code(bad_code), .bank_open(bank_open)
);

// File: tb/tb_sdram_cmd_checker.sv
module tb_sdram_cmd_checker;
  localparam int CLK_P = 10;

  localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                         C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000,
                         C_BST = 4'b0110, C_NOP = 4'b0111, C_DES = 4'b1111;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic        cmd_ok, cmd_bad;
  logic [3:0]  bad_code;
  logic [3:0]  bank_open;

  int checks = 0, errs = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_checker dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cmd_ok(cmd_ok), .cmd_bad(cmd_bad),
    .bad_code(bad_code), .bank_open(bank_open)
  );

  task automatic pins(input logic [3:0] c, input logic [1:0] b, input logic ap, input logic [2:0] lo);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    addr = '0;
    addr[10] = ap;
    addr[2:0] = lo;
  endtask

  task automatic reset_dut();
    pins(C_NOP, 2'd0, 1'b0, 3'd0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // issue one command at the next rising edge, check its verdict at the following falling edge
  task automatic cmd(input logic [3:0] c, input logic [1:0] b, input logic ap, input logic [2:0] lo,
                     input logic exp_ok, input logic [3:0] exp_code, input string req);
    pins(c, b, ap, lo);
    @(posedge clk);
    #1 pins(C_NOP, 2'd0, 1'b0, 3'd0);
    @(negedge clk);
    checks++;
    if (cmd_ok !== exp_ok || cmd_bad !== !exp_ok || bad_code !== exp_code) begin
      errs++;
      $display("FAIL %s: ok=%0b bad=%0b code=%0d, expected ok=%0b code=%0d",
               req, cmd_ok, cmd_bad, bad_code, exp_ok, exp_code);
    end
  endtask

  task automatic quiet(input logic [3:0] c, input string req);
    pins(c, 2'd1, 1'b1, 3'd0);
    @(posedge clk);
    #1 pins(C_NOP, 2'd0, 1'b0, 3'd0);
    @(negedge clk);
    checks++;
    if (cmd_ok !== 1'b0 || cmd_bad !== 1'b0 || bad_code !== 4'd0) begin
      errs++;
      $display("FAIL %s: ok=%0b bad=%0b code=%0d, expected no pulse", req, cmd_ok, cmd_bad, bad_code);
    end
  endtask

  task automatic banks(input logic [3:0] exp, input string req);
    checks++;
    if (bank_open !== exp) begin
      errs++;
      $display("FAIL %s: bank_open=%b expected %b", req, bank_open, exp);
    end
  endtask

  task automatic t_reset_state();
    reset_dut();
    @(negedge clk);
    banks(4'b0000, "R1 reset banks");
    checks++;
    if (cmd_ok !== 1'b0 || cmd_bad !== 1'b0) begin
      errs++;
      $display("FAIL R1 reset pulses: ok=%0b bad=%0b expected 0 0", cmd_ok, cmd_bad);
    end
    quiet(C_NOP, "R1 nop silent");
    quiet(C_DES, "R1 deselect silent");
  endtask

  task automatic t_open_and_rcd();
    reset_dut();
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R3 activate");      // E0
    banks(4'b0001, "R3 bank0 open");
    cmd(C_RD, 2'd0, 1'b0, 3'd0, 1'b0, 4'd9, "R4 read k=1");       // E1
    cmd(C_RD, 2'd0, 1'b0, 3'd0, 1'b0, 4'd9, "R4 read k=2");       // E2
    cmd(C_RD, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R4 read k=3");       // E3
    cmd(C_RD, 2'd1, 1'b0, 3'd0, 1'b0, 4'd3, "R4 read closed");    // E4
    banks(4'b0001, "R2 reject keeps banks");
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b0, 4'd3, "R3 activate open"); // E5
  endtask

  task automatic t_act_spacing();
    reset_dut();
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R5 act b0");         // E0
    cmd(C_ACT, 2'd1, 1'b0, 3'd0, 1'b0, 4'd6, "R5 rrd k=1");        // E1
    banks(4'b0001, "R2 rrd reject keeps banks");
    cmd(C_ACT, 2'd1, 1'b0, 3'd0, 1'b1, 4'd0, "R5 rrd k=2");        // E2
    cmd(C_PRE, 2'd0, 1'b0, 3'd0, 1'b0, 4'd7, "R6 ras k=3");        // E3
    idle(2);
    cmd(C_PRE, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R6 ras k=6");        // E6
    banks(4'b0010, "R6 single precharge");
    idle(1);
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b0, 4'd5, "R5 rc k=8");         // E8
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R5 rc k=9");         // E9
  endtask

  task automatic t_pre_all();
    reset_dut();
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R6 act b0");         // E0
    idle(1);
    cmd(C_ACT, 2'd1, 1'b0, 3'd0, 1'b1, 4'd0, "R6 act b1");         // E2
    idle(3);
    cmd(C_PRE, 2'd3, 1'b1, 3'd0, 1'b0, 4'd7, "R6 all ras b1 k=4"); // E6
    idle(1);
    cmd(C_PRE, 2'd3, 1'b1, 3'd0, 1'b1, 4'd0, "R6 all ok");         // E8
    banks(4'b0000, "R6 all closed");
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b0, 4'd8, "R6 rp k=1");         // E9
    idle(1);
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R6 rp k=3");         // E11
    cmd(C_PRE, 2'd3, 1'b0, 3'd0, 1'b1, 4'd0, "R6 closed bank pre");// E12
    banks(4'b0001, "R6 closed pre no effect");
  endtask

  task automatic t_write_ap();
    reset_dut();
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R7 act");            // E0
    idle(2);
    cmd(C_WR, 2'd0, 1'b1, 3'd0, 1'b1, 4'd0, "R7 write ap");        // E3
    banks(4'b0000, "R7 ap closes bank");
    cmd(C_PRE, 2'd2, 1'b0, 3'd0, 1'b0, 4'd2, "R8 pre in ap burst");// E4
    cmd(C_RD, 2'd0, 1'b0, 3'd0, 1'b0, 4'd2, "R8 read in ap burst");// E5
    idle(4);
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b0, 4'd8, "R7 write rec k=7");  // E10
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R7 write rec k=8");  // E11
  endtask

  task automatic t_read_ap();
    reset_dut();
    cmd(C_ACT, 2'd1, 1'b0, 3'd0, 1'b1, 4'd0, "R7 act b1");         // E0
    idle(4);
    cmd(C_RD, 2'd1, 1'b1, 3'd0, 1'b1, 4'd0, "R7 read ap");         // E5
    idle(4);
    cmd(C_ACT, 2'd1, 1'b0, 3'd0, 1'b0, 4'd8, "R7 read rec k=5");   // E10
    cmd(C_ACT, 2'd1, 1'b0, 3'd0, 1'b1, 4'd0, "R7 read rec k=6");   // E11
  endtask

  task automatic t_mode_fullpage();
    reset_dut();
    cmd(C_MRS, 2'd0, 1'b0, 3'b101, 1'b0, 4'd12, "R12 reserved bl");  // E0
    cmd(C_MRS, 2'd0, 1'b0, 3'b111, 1'b1, 4'd0, "R12 full page set"); // E1
    cmd(C_REF, 2'd0, 1'b0, 3'd0, 1'b0, 4'd1, "R12 rsc");             // E2
    cmd(C_REF, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R11 refresh idle");    // E3
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b0, 4'd5, "R11 ref to act k=1");  // E4
    idle(7);
    cmd(C_ACT, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R11 ref to act k=9");  // E12
    idle(2);
    cmd(C_RD, 2'd0, 1'b1, 3'd0, 1'b0, 4'd10, "R9 ap full page");     // E15
    cmd(C_BST, 2'd0, 1'b0, 3'd0, 1'b0, 4'd11, "R10 stop no burst");  // E16
    cmd(C_RD, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R10 full page read");   // E17
    idle(12);
    cmd(C_BST, 2'd0, 1'b0, 3'd0, 1'b1, 4'd0, "R10 stop in burst");   // E30
    cmd(C_BST, 2'd0, 1'b0, 3'd0, 1'b0, 4'd11, "R10 stop after stop");// E31
    cmd(C_REF, 2'd0, 1'b0, 3'd0, 1'b0, 4'd4, "R11 refresh open");    // E32
    cmd(C_MRS, 2'd0, 1'b0, 3'b010, 1'b0, 4'd4, "R11 mode set open"); // E33
  endtask

  task automatic t_bl_field();
    reset_dut();
    cmd(C_MRS, 2'd0, 1'b0, 3'b000, 1'b1, 4'd0, "R12 set bl1");       // E0
    idle(1);
    cmd(C_ACT, 2'd2, 1'b0, 3'd0, 1'b1, 4'd0, "R12 act b2");          // E2
    idle(5);
    cmd(C_WR, 2'd2, 1'b1, 3'd0, 1'b1, 4'd0, "R12 write ap bl1");     // E8
    cmd(C_PRE, 2'd1, 1'b0, 3'd0, 1'b1, 4'd0, "R8 bl1 burst over");   // E9
    idle(2);
    cmd(C_ACT, 2'd2, 1'b0, 3'd0, 1'b0, 4'd8, "R12 bl1 rec k=4");     // E12
    cmd(C_ACT, 2'd2, 1'b0, 3'd0, 1'b1, 4'd0, "R12 bl1 rec k=5");     // E13
  endtask

  task automatic t_priority();
    reset_dut();
    cmd(C_MRS, 2'd0, 1'b0, 3'b010, 1'b1, 4'd0, "R13 mode set");      // E0
    cmd(C_RD, 2'd0, 1'b0, 3'd0, 1'b0, 4'd1, "R13 rsc over closed");  // E1
    cmd(C_RD, 2'd0, 1'b0, 3'd0, 1'b0, 4'd3, "R13 closed after rsc"); // E2
    cmd(C_ACT, 2'd3, 1'b0, 3'd0, 1'b1, 4'd0, "R13 act b3");          // E3
    cmd(C_ACT, 2'd3, 1'b0, 3'd0, 1'b0, 4'd3, "R13 open over rc");    // E4
  endtask

  initial begin
    pins(C_NOP, 2'd0, 1'b0, 3'd0);
    t_reset_state();
    t_open_and_rcd();
    t_act_spacing();
    t_pre_all();
    t_write_ap();
    t_read_ap();
    t_mode_fullpage();
    t_bl_field();
    t_priority();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule